// File: doc/BRIEF.md
# Masked Odd-Lane Duplicate Unit

This block is one datapath stage beside a vector register file. It takes a source vector made of 32-bit lanes and copies every odd lane into its own slot and into the even slot just below it. It then writes that result over the current value of the destination register. The lanes are moved as raw bit patterns, so no lane is ever interpreted as a number.

How many lanes are written, and what happens to the bits above them, depends on a vector-length code and an encoding mode. There are three modes: a legacy mode, an unmasked vector mode and a masked vector mode. Only the masked mode applies a per-lane writemask. Lanes that the mask turns off either keep their old value or are cleared.

The two vector modes also check a 4-bit reserved specifier field and raise a fault if it is not all ones. A request is taken on an input strobe, and the answer appears on the registered outputs one clock later.

Top module: `vdup_odd_unit`

## Requirements
- R1: For every pair index k with both lanes written, destination lanes 2k and 2k+1 both equal source lane 2k+1, bit for bit. The even source lanes never appear in the result.
- R2: In the two vector modes (mode_sel 1, 2 or 3), vlen_sel sets the number of written lanes. Code 0 gives LANES/4 lanes, code 1 gives LANES/2 lanes, and codes 2 and 3 give all LANES lanes.
- R3: In masked mode (mode_sel 2 or 3), a lane below the active count takes the duplicated source value when mask_en is 0 or when its wmask bit is 1.
- R4: In masked mode, with mask_en set, a lane below the active count whose wmask bit is 0 keeps its old_dst value when zero_mask is 0. It becomes zero when zero_mask is 1.
- R5: In the two vector modes, every result bit above the active lanes is zero.
- R6: In legacy mode (mode_sel 0), exactly LANES/4 lanes are written and vlen_sel, wmask, mask_en and zero_mask have no effect. The bits above those lanes keep their old_dst value, and the mode never faults.
- R7: In unmasked vector mode (mode_sel 1), wmask, mask_en and zero_mask have no effect, and every active lane is written.
- R8: When mode_sel is not 0 and rsvd_spec is not 4'b1111, fault is 1 and result equals old_dst unchanged. Otherwise fault is 0.
- R9: Writemask bits at or above the active lane count have no effect on the result.
- R10: out_valid is 1 exactly in the cycle after a cycle with in_valid high. result and fault take the new request's values on that same edge and hold them until the next accepted request. With rst_n low at an edge, out_valid and fault are 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; all inputs are sampled on this cycle |
| src | input | LANE_W*LANES | Source vector |
| old_dst | input | LANE_W*LANES | Current destination value |
| vlen_sel | input | 2 | Vector length code (0: quarter, 1: half, 2/3: full) |
| mode_sel | input | 2 | Encoding mode (0: legacy, 1: unmasked vector, 2/3: masked vector) |
| wmask | input | LANES | Per-lane writemask |
| mask_en | input | 1 | Enables the writemask in masked mode |
| zero_mask | input | 1 | 1: masked-off lanes are zeroed, 0: merged |
| rsvd_spec | input | 4 | Reserved specifier field, must be 4'b1111 in vector modes |
| out_valid | output | 1 | Result valid pulse |
| result | output | LANE_W*LANES | New destination value |
| fault | output | 1 | Undefined-opcode fault flag |

## Verification
The bench builds the unit with LANE_W=8 and LANES=16. This keeps the full sixteen-lane mask and the quarter/half/full length structure, while a 128-bit vector makes each transaction cheap. At that size it can sweep every mode code, every length code, both mask flags and all sixteen reserved-field values against a set of mask patterns. The mask patterns include ones with bits set only above the active lanes. Random source and destination data per request expose any lane taken from the wrong place or any bit that leaks across the length boundary.

// File: rtl/vdup_odd_unit.sv
module vdup_odd_unit #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANE_W*LANES-1:0] src,
  input  logic [LANE_W*LANES-1:0] old_dst,
  input  logic [1:0]              vlen_sel,
  input  logic [1:0]              mode_sel,
  input  logic [LANES-1:0]        wmask,
  input  logic                    mask_en,
  input  logic                    zero_mask,
  input  logic [3:0]              rsvd_spec,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result,
  output logic                    fault
);
  localparam int VW    = LANE_W * LANES;
  localparam int PAIRS = LANES / 2;
  localparam logic [LANES-1:0] ALL_ON = '1;
  localparam logic [LANES-1:0] ACT_Q  = ALL_ON >> (LANES - LANES / 4);
  localparam logic [LANES-1:0] ACT_H  = ALL_ON >> (LANES - LANES / 2);

  logic             is_leg, is_msk, bad_spec;
  logic [LANES-1:0] act, take;
  logic [VW-1:0]    dup, merged, next_dst;

  assign is_leg   = (mode_sel == 2'd0);
  assign is_msk   = mode_sel[1];
  assign bad_spec = !is_leg && (rsvd_spec != 4'b1111);

  always_comb begin
    if (is_leg)               act = ACT_Q;
    else if (vlen_sel == 2'd0) act = ACT_Q;
    else if (vlen_sel == 2'd1) act = ACT_H;
    else                       act = ALL_ON;
  end

  assign take = act & ~({LANES{is_msk & mask_en}} & ~wmask);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign dup[(2*p)*LANE_W   +: LANE_W] = src[(2*p+1)*LANE_W +: LANE_W];
    assign dup[(2*p+1)*LANE_W +: LANE_W] = src[(2*p+1)*LANE_W +: LANE_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] keep;
    assign keep = (act[l] ? !zero_mask : is_leg) ? old_dst[l*LANE_W +: LANE_W] : '0;
    assign merged[l*LANE_W +: LANE_W] = take[l] ? dup[l*LANE_W +: LANE_W] : keep;
  end

  assign next_dst = bad_spec ? old_dst : merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fault     <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fault  <= bad_spec;
        result <= next_dst;
      end
    end
  end
endmodule

// File: rtl/vdup_odd_unit_chk.sv
module vdup_odd_unit_chk #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [LANE_W*LANES-1:0] src,
  input logic [LANE_W*LANES-1:0] old_dst,
  input logic [1:0]              vlen_sel,
  input logic [1:0]              mode_sel,
  input logic [3:0]              rsvd_spec,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] result,
  input logic                    fault
);
  localparam int VW = LANE_W * LANES;
  localparam int QW = VW / 4;

  logic primed;
  always_ff @(posedge clk) primed <= rst_n;

  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !fault));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (out_valid == $past(in_valid)));

  a_r8_fault_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(in_valid)) |->
      (fault == ($past(mode_sel) != 2'd0 && $past(rsvd_spec) != 4'b1111)));

  a_r8_fault_keeps_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(in_valid) && fault) |-> (result == $past(old_dst)));

  a_r6_legacy_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(in_valid) && $past(mode_sel) == 2'd0) |->
      (result[VW-1:QW] == $past(old_dst[VW-1:QW])));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(in_valid) && !fault && $past(mode_sel) != 2'd0 &&
     $past(vlen_sel) == 2'd0) |-> (result[VW-1:QW] == '0));

  for (genvar p = 0; p < LANES / 8; p++) begin : g_r1
    a_r1_pair_dup: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(in_valid) && !fault && $past(mode_sel) == 2'd1) |->
        (result[(2*p)*LANE_W +: LANE_W] == $past(src[(2*p+1)*LANE_W +: LANE_W]) &&
         result[(2*p+1)*LANE_W +: LANE_W] == $past(src[(2*p+1)*LANE_W +: LANE_W])));
  end
endmodule

bind vdup_odd_unit vdup_odd_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
  .vlen_sel(vlen_sel), .mode_sel(mode_sel), .rsvd_spec(rsvd_spec),
  .out_valid(out_valid), .result(result), .fault(fault)
);

// File: tb/vdup_odd_unit_test.sv
module vdup_odd_unit_test;
  localparam int PERIOD = 10;
  localparam int W  = 8;
  localparam int L  = 16;
  localparam int VW = W * L;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] src = '0, old_dst = '0;
  logic [1:0]    vlen_sel = '0, mode_sel = '0;
  logic [L-1:0]  wmask = '0;
  logic          mask_en = 1'b0, zero_mask = 1'b0;
  logic [3:0]    rsvd_spec = 4'hF;
  logic          out_valid, fault;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;

  always #(PERIOD / 2) clk = ~clk;

  vdup_odd_unit #(.LANE_W(W), .LANES(L)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .vlen_sel(vlen_sel), .mode_sel(mode_sel), .wmask(wmask), .mask_en(mask_en),
    .zero_mask(zero_mask), .rsvd_spec(rsvd_spec),
    .out_valid(out_valid), .result(result), .fault(fault)
  );

  function automatic int act_count(logic [1:0] md, logic [1:0] vl);
    if (md == 2'd0 || vl == 2'd0) return L / 4;
    if (vl == 2'd1) return L / 2;
    return L;
  endfunction

  function automatic logic exp_fault(logic [1:0] md, logic [3:0] rs);
    return (md != 2'd0) && (rs != 4'hF);
  endfunction

  function automatic logic [VW-1:0] exp_result(
      logic [VW-1:0] s, logic [VW-1:0] o, logic [1:0] vl, logic [1:0] md,
      logic [L-1:0] wm, logic me, logic zm, logic [3:0] rs);
    logic [VW-1:0] r;
    int n;
    if (exp_fault(md, rs)) return o;
    n = act_count(md, vl);
    for (int i = 0; i < L; i++) begin
      logic [W-1:0] odd;
      odd = s[(i / 2 * 2 + 1) * W +: W];
      if (i < n) begin
        if (md >= 2'd2 && me && !wm[i]) r[i*W +: W] = zm ? '0 : o[i*W +: W];
        else                           r[i*W +: W] = odd;
      end else begin
        r[i*W +: W] = (md == 2'd0) ? o[i*W +: W] : '0;
      end
    end
    return r;
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pick_mask(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'hAAAA;
      3: return 16'h5555;
      4: return 16'h000F;
      5: return 16'hFFF0;
      6: return 16'h00FF;
      7: return 16'hFF00;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic run_one(logic [1:0] md, logic [1:0] vl, logic me, logic zm,
                         logic [3:0] rs, logic [L-1:0] wm);
    logic [VW-1:0] s, o, er;
    logic ef;
    string tag;
    s = {$urandom, $urandom, $urandom, $urandom};
    o = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    src = s; old_dst = o; vlen_sel = vl; mode_sel = md; wmask = wm;
    mask_en = me; zero_mask = zm; rsvd_spec = rs; in_valid = 1'b1;
    er = exp_result(s, o, vl, md, wm, me, zm, rs);
    ef = exp_fault(md, rs);
    @(negedge clk);
    in_valid = 1'b0;
    src = ~s; old_dst = ~o; wmask = ~wm;
    if (ef)             tag = "R8";
    else if (md == 0)   tag = "R1 R6";
    else if (md == 1)   tag = "R1 R2 R5 R7";
    else if (me && (wm >> act_count(md, vl)) != '0) tag = "R3 R4 R5 R9";
    else                tag = "R1 R2 R3 R4 R5";
    check_bit("R10 out_valid pulse", out_valid, 1'b1);
    check_bit("R8 fault", fault, ef);
    check_vec(tag, result, er);
    @(negedge clk);
    check_bit("R10 out_valid low when idle", out_valid, 1'b0);
    check_vec("R10 result held", result, er);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R10 reset out_valid", out_valid, 1'b0);
    check_bit("R10 reset fault", fault, 1'b0);
    rst_n = 1'b1;
    for (int md = 0; md < 4; md++)
      for (int vl = 0; vl < 4; vl++)
        for (int me = 0; me < 2; me++)
          for (int zm = 0; zm < 2; zm++)
            for (int rs = 0; rs < 16; rs++)
              for (int k = 0; k < 10; k++)
                run_one(2'(md), 2'(vl), 1'(me), 1'(zm), 4'(rs), pick_mask(k));
    run_one(2'd1, 2'd0, 1'b0, 1'b0, 4'hE, 16'h0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R10 reset clears fault", fault, 1'b0);
    check_bit("R10 reset clears out_valid", out_valid, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule